// File: doc/BRIEF.md
# Isochronous IN Double-Buffered Transmit Store

This block holds outgoing data for a single isochronous IN endpoint in two equal buffers. At any moment one buffer belongs to the CPU, which appends bytes to it, and the other belongs to the bus engine, which drains it byte by byte while building the data packet. Ownership of the two buffers flips only when a start-of-frame event arrives. Completing a transfer does not flip ownership, raises no interrupt and produces no handshake.

On each start-of-frame the buffer the CPU filled during the last frame passes to the bus side. The buffer returning to the CPU is emptied, so any bytes the bus side left unread are discarded. A sticky start-of-frame interrupt is raised every time. The CPU is expected to refill its buffer in response. A write into a full CPU buffer and a read from an empty bus buffer are both recorded in sticky error bits. A status word reports which buffer the CPU owns, the two error bits and three handshake flags. Isochronous traffic never sets the handshake flags.

Top module: `iso_pingpong_tx`

## Requirements
- R1: After reset both buffers are empty, buffer 0 belongs to the CPU, `sof_irq_o` is low and every `status_o` bit is 0.
- R2: Each accepted CPU write appends one byte to the CPU-owned buffer. `cpu_fill_o` shows that buffer's byte count. Bytes written are not visible on the bus side until the next start-of-frame.
- R3: A start-of-frame swaps ownership, with `status_o[0]` giving the index of the CPU-owned buffer. On the bus side, `bus_cnt_o` then shows the number of unread bytes, and the bytes leave in write order on `bus_rd_data_o`, one per `bus_rd_i` pulse.
- R4: At a start-of-frame, the buffer that passes back to the CPU is emptied. Bytes the bus side had not read are lost.
- R5: Every start-of-frame sets `sof_irq_o` on the next cycle, whether or not `sof_bad_i` marks it as corrupted. The flag stays set until a cycle with `sts_clr_i[0]` high and no start-of-frame.
- R6: A CPU write while the CPU buffer holds DEPTH bytes is dropped and sets the overflow bit `status_o[1]`. The bit stays set until it is cleared by `sts_clr_i[1]` in a cycle with no new overflow.
- R7: When the bus buffer is empty, `bus_rd_data_o` reads 0. A read in that state sets the underrun bit `status_o[2]`, which is cleared by `sts_clr_i[2]` in a cycle with no new underrun.
- R8: A CPU write in the same cycle as a start-of-frame goes into the buffer that becomes CPU-owned, as its first byte.
- R9: A bus read in the same cycle as a start-of-frame has no effect. It pops nothing and sets no underrun.
- R10: The handshake flags `status_o[5:3]` (stall, nak, ack) stay 0 through every transfer. `sof_irq_o` is the only interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_wdata_i | input | DATA_W | CPU write byte |
| cpu_fill_o | output | CNT_W | Byte count of the CPU-owned buffer |
| bus_rd_i | input | 1 | Bus-side read strobe (pop) |
| bus_rd_data_o | output | DATA_W | Head byte of the bus-owned buffer, 0 when it is empty |
| bus_empty_o | output | 1 | Bus-owned buffer has no unread byte |
| bus_cnt_o | output | CNT_W | Unread bytes in the bus-owned buffer |
| sof_i | input | 1 | Start-of-frame event |
| sof_bad_i | input | 1 | Start-of-frame flagged as corrupted |
| sts_clr_i | input | 3 | Write-one-to-clear: [0] interrupt, [1] overflow, [2] underrun |
| sof_irq_o | output | 1 | Sticky start-of-frame interrupt |
| status_o | output | 6 | {ack, nak, stall, underrun, overflow, cpu buffer index} |

## Verification
The hardest situations to reach are the ones where an event coincides with a start-of-frame. These are a write landing as the first byte of a buffer that is being emptied in that same cycle, and a read that must be ignored while ownership flips. Just as hard is a swap that discards bytes the bus side left half-read. The stimulus reaches these states directly: it fills a buffer past DEPTH, partly drains the other, and then issues start-of-frame pulses together with writes, reads and clear bits. A long run of random strobes then keeps all of these overlapping, and a behavioural model built from two queues follows every cycle.

// File: rtl/iso_pp_pkg.sv
// Package: shared status layout for the isochronous double-buffered store.
// Assumes: consumers pack/unpack status through iso_status_t only.
package iso_pp_pkg;

    typedef struct packed {
        logic ack;
        logic nak;
        logic stall;
        logic underrun;
        logic overflow;
        logic cpu_sel;
    } iso_status_t;

    localparam int CLR_IRQ = 0;
    localparam int CLR_OVF = 1;
    localparam int CLR_UDF = 2;
    localparam int CLR_W   = 3;

endpackage

// File: rtl/iso_pp_buf.sv
// Module: one linear buffer with a write pointer and a read pointer.
// Assumes: the caller never writes when full (unless clearing in the same
// cycle) and never reads when empty. Clearing wins over reading, and a write
// in the clearing cycle becomes entry 0.
module iso_pp_buf #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [CNT_W-1:0]  fill_o,
    output logic [CNT_W-1:0]  avail_o,
    output logic              full_o,
    output logic              empty_o
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  wr_ptr;
    logic [CNT_W-1:0]  rd_ptr;
    logic [PTR_W-1:0]  wr_idx;
    logic [PTR_W-1:0]  rd_idx;

    assign wr_idx = clr_i ? '0 : wr_ptr[PTR_W-1:0];
    assign rd_idx = rd_ptr[PTR_W-1:0];

    // Storage write: place the byte at the write position.
    always_ff @(posedge clk) begin
        if (wr_i) begin
            mem[wr_idx] <= wr_data_i;
        end
    end

    // Pointer update: clear, append and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (clr_i) begin
            wr_ptr <= wr_i ? CNT_W'(1) : '0;
            rd_ptr <= '0;
        end else begin
            if (wr_i) wr_ptr <= wr_ptr + CNT_W'(1);
            if (rd_i) rd_ptr <= rd_ptr + CNT_W'(1);
        end
    end

    // Derived occupancy views.
    always_comb begin
        fill_o    = wr_ptr;
        avail_o   = wr_ptr - rd_ptr;
        full_o    = (wr_ptr == CNT_W'(DEPTH));
        empty_o   = (wr_ptr == rd_ptr);
        rd_data_o = mem[rd_idx];
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |-> !full_o);

    // R7
    no_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |-> !empty_o);

    // R4
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !wr_i) |=> (fill_o == '0));

endmodule

// File: rtl/iso_pp_ctrl.sv
// Module: ownership register and sticky flags (interrupt, overflow, underrun).
// Assumes: every sof_i pulse counts as a frame start, corrupted or not.
// A set in the same cycle wins over a write-one-to-clear.
module iso_pp_ctrl #(
    parameter int CLR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_i,
    input  logic             ovf_ev_i,
    input  logic             udf_ev_i,
    input  logic [CLR_W-1:0] clr_i,
    output logic             cpu_sel_o,
    output logic             sof_irq_o,
    output logic             ovf_o,
    output logic             udf_o
);
    import iso_pp_pkg::*;

    // Ownership flip on every frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_sel_o <= 1'b0;
        else if (sof_i) cpu_sel_o <= ~cpu_sel_o;
    end

    // Sticky flags: set has priority over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sof_irq_o <= 1'b0;
            ovf_o     <= 1'b0;
            udf_o     <= 1'b0;
        end else begin
            sof_irq_o <= sof_i    | (sof_irq_o & ~clr_i[CLR_IRQ]);
            ovf_o     <= ovf_ev_i | (ovf_o     & ~clr_i[CLR_OVF]);
            udf_o     <= udf_ev_i | (udf_o     & ~clr_i[CLR_UDF]);
        end
    end

    // R5
    sof_irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |=> sof_irq_o);

    // R5
    sof_irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_irq_o && !clr_i[CLR_IRQ]) |=> sof_irq_o);

    // R3
    role_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |=> (cpu_sel_o != $past(cpu_sel_o)));

    // R2
    role_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_i |=> $stable(cpu_sel_o));

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_i[CLR_OVF]) |=> ovf_o);

    // R7
    udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (udf_o && !clr_i[CLR_UDF]) |=> udf_o);

endmodule

// File: rtl/iso_pingpong_tx.sv
// Module: isochronous IN transmit store with two buffers whose CPU/bus roles
// swap on each start-of-frame.
// Assumes: a start-of-frame is applied before a same-cycle write (the write
// targets the new CPU buffer) and it cancels a same-cycle bus read. The
// handshake flags are reported but never set by isochronous traffic.
module iso_pingpong_tx #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic [CNT_W-1:0]  cpu_fill_o,
    input  logic              bus_rd_i,
    output logic [DATA_W-1:0] bus_rd_data_o,
    output logic              bus_empty_o,
    output logic [CNT_W-1:0]  bus_cnt_o,
    input  logic              sof_i,
    input  logic              sof_bad_i,
    input  logic [2:0]        sts_clr_i,
    output logic              sof_irq_o,
    output logic [5:0]        status_o
);
    import iso_pp_pkg::*;

    localparam int NBUF = 2;

    logic              cpu_sel;
    logic              bus_sel;
    logic              nxt_cpu_sel;
    logic              ovf_ev;
    logic              udf_ev;
    logic              ovf_flag;
    logic              udf_flag;
    logic [NBUF-1:0]   b_clr;
    logic [NBUF-1:0]   b_wr;
    logic [NBUF-1:0]   b_rd;
    logic [NBUF-1:0]   b_full;
    logic [NBUF-1:0]   b_empty;
    logic [DATA_W-1:0] b_rdata [NBUF];
    logic [CNT_W-1:0]  b_fill  [NBUF];
    logic [CNT_W-1:0]  b_avail [NBUF];
    iso_status_t       sts;

    // Role selection for this cycle and the one after a frame start.
    always_comb begin
        bus_sel     = ~cpu_sel;
        nxt_cpu_sel = cpu_sel ^ sof_i;
    end

    // Per-buffer steering and storage.
    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        logic owned_now;
        logic owned_next;

        // Strobe steering for buffer g.
        always_comb begin
            owned_now  = (cpu_sel == 1'(g));
            owned_next = (nxt_cpu_sel == 1'(g));
            b_clr[g]   = sof_i && owned_next;
            b_wr[g]    = cpu_wr_i && owned_next && (sof_i || !b_full[g]);
            b_rd[g]    = bus_rd_i && !sof_i && !owned_now && !b_empty[g];
        end

        iso_pp_buf #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) i_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (b_clr[g]),
            .wr_i      (b_wr[g]),
            .wr_data_i (cpu_wdata_i),
            .rd_i      (b_rd[g]),
            .rd_data_o (b_rdata[g]),
            .fill_o    (b_fill[g]),
            .avail_o   (b_avail[g]),
            .full_o    (b_full[g]),
            .empty_o   (b_empty[g])
        );
    end

    // Error events: only counted when no frame start overrides the strobe.
    always_comb begin
        ovf_ev = cpu_wr_i && !sof_i && b_full[cpu_sel];
        udf_ev = bus_rd_i && !sof_i && b_empty[bus_sel];
    end

    iso_pp_ctrl #(
        .CLR_W (CLR_W)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sof_i     (sof_i),
        .ovf_ev_i  (ovf_ev),
        .udf_ev_i  (udf_ev),
        .clr_i     (sts_clr_i),
        .cpu_sel_o (cpu_sel),
        .sof_irq_o (sof_irq_o),
        .ovf_o     (ovf_flag),
        .udf_o     (udf_flag)
    );

    // Output views of the two roles and the status word.
    always_comb begin
        cpu_fill_o    = b_fill[cpu_sel];
        bus_empty_o   = b_empty[bus_sel];
        bus_cnt_o     = b_avail[bus_sel];
        bus_rd_data_o = b_empty[bus_sel] ? '0 : b_rdata[bus_sel];
        sts.ack       = 1'b0;
        sts.nak       = 1'b0;
        sts.stall     = 1'b0;
        sts.underrun  = udf_flag;
        sts.overflow  = ovf_flag;
        sts.cpu_sel   = cpu_sel;
        status_o      = sts;
    end

    // R5
    corrupt_sof_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_i && sof_bad_i) |=> sof_irq_o);

    // R8
    sof_write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_i && cpu_wr_i) |=> (cpu_fill_o == CNT_W'(1)));

    // R9
    sof_read_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_i && !udf_flag && !sts_clr_i[CLR_UDF]) |=> !status_o[2]);

    // R3
    bus_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof_i && !bus_rd_i) |=> $stable(bus_cnt_o));

endmodule

// File: tb/test_iso_pingpong_tx.sv
`timescale 1ns/1ps
module test_iso_pingpong_tx;

    localparam int DW    = 8;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_wr_i = 1'b0;
    logic [DW-1:0] cpu_wdata_i = '0;
    logic [CW-1:0] cpu_fill_o;
    logic          bus_rd_i = 1'b0;
    logic [DW-1:0] bus_rd_data_o;
    logic          bus_empty_o;
    logic [CW-1:0] bus_cnt_o;
    logic          sof_i = 1'b0;
    logic          sof_bad_i = 1'b0;
    logic [2:0]    sts_clr_i = '0;
    logic          sof_irq_o;
    logic [5:0]    status_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference model state
    logic [DW-1:0] q0[$];
    logic [DW-1:0] q1[$];
    int m_cpu = 0;
    bit m_irq = 0, m_ovf = 0, m_udf = 0;

    always #5 clk = ~clk;

    iso_pingpong_tx #(.DATA_W(DW), .DEPTH(DEPTH)) i_iso_pingpong_tx (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_i(cpu_wr_i), .cpu_wdata_i(cpu_wdata_i), .cpu_fill_o(cpu_fill_o),
        .bus_rd_i(bus_rd_i), .bus_rd_data_o(bus_rd_data_o),
        .bus_empty_o(bus_empty_o), .bus_cnt_o(bus_cnt_o),
        .sof_i(sof_i), .sof_bad_i(sof_bad_i), .sts_clr_i(sts_clr_i),
        .sof_irq_o(sof_irq_o), .status_o(status_o)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int cpu_sz();
        return (m_cpu == 1) ? q1.size() : q0.size();
    endfunction

    function automatic int bus_sz();
        return (m_cpu == 1) ? q0.size() : q1.size();
    endfunction

    function automatic logic [DW-1:0] bus_head();
        if (bus_sz() == 0) return '0;
        return (m_cpu == 1) ? q0[0] : q1[0];
    endfunction

    task automatic compare_all();
        chk("R2", "cpu_fill_o", 32'(cpu_fill_o), 32'(cpu_sz()));
        chk("R3", "bus_cnt_o", 32'(bus_cnt_o), 32'(bus_sz()));
        chk("R3", "bus_empty_o", 32'(bus_empty_o), 32'(bus_sz() == 0));
        chk("R7", "bus_rd_data_o", 32'(bus_rd_data_o), 32'(bus_head()));
        chk("R5", "sof_irq_o", 32'(sof_irq_o), 32'(m_irq));
        chk("R3", "status cpu index", 32'(status_o[0]), 32'(m_cpu));
        chk("R6", "status overflow", 32'(status_o[1]), 32'(m_ovf));
        chk("R7", "status underrun", 32'(status_o[2]), 32'(m_udf));
        chk("R10", "handshake flags", 32'(status_o[5:3]), 32'(0));
    endtask

    // Model step using the inputs applied in this cycle.
    task automatic model_step(bit w, logic [DW-1:0] d, bit r, bit s, logic [2:0] clr);
        bit ovf_set = 0, udf_set = 0;
        if (s) begin
            m_cpu = 1 - m_cpu;
            if (m_cpu == 1) q1.delete(); else q0.delete();
            if (w) begin
                if (m_cpu == 1) q1.push_back(d); else q0.push_back(d);
            end
        end else begin
            if (w) begin
                if (cpu_sz() == DEPTH) ovf_set = 1;
                else if (m_cpu == 1) q1.push_back(d);
                else q0.push_back(d);
            end
            if (r) begin
                if (bus_sz() == 0) udf_set = 1;
                else if (m_cpu == 1) void'(q0.pop_front());
                else void'(q1.pop_front());
            end
        end
        m_irq = s | (m_irq & !clr[0]);
        m_ovf = ovf_set | (m_ovf & !clr[1]);
        m_udf = udf_set | (m_udf & !clr[2]);
    endtask

    // One clock: check, drive, advance the model, return to the falling edge.
    task automatic cyc(bit w, logic [DW-1:0] d, bit r, bit s, bit bad_sof, logic [2:0] clr);
        compare_all();
        cpu_wr_i = w; cpu_wdata_i = d; bus_rd_i = r;
        sof_i = s; sof_bad_i = bad_sof; sts_clr_i = clr;
        @(posedge clk);
        model_step(w, d, r, s, clr);
        @(negedge clk);
        cpu_wr_i = 0; bus_rd_i = 0; sof_i = 0; sof_bad_i = 0; sts_clr_i = '0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset cpu_fill_o", 32'(cpu_fill_o), 0);
        chk("R1", "reset bus_empty_o", 32'(bus_empty_o), 1);
        chk("R1", "reset sof_irq_o", 32'(sof_irq_o), 0);
        chk("R1", "reset status_o", 32'(status_o), 0);
        rst_n = 1'b1;

        // R2: writes go to CPU buffer only
        for (int i = 0; i < 5; i++) cyc(1, DW'(8'h10 + i), 0, 0, 0, 0);
        chk("R2", "bus not yet visible", 32'(bus_cnt_o), 0);
        // R3: swap on frame start
        cyc(0, 0, 0, 1, 0, 0);
        chk("R3", "bus_cnt after swap", 32'(bus_cnt_o), 5);
        chk("R3", "first byte", 32'(bus_rd_data_o), 32'h10);
        cyc(0, 0, 1, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 1);
        chk("R3", "third byte", 32'(bus_rd_data_o), 32'h12);
        // R8: corrupted frame start with a write in the same cycle; R4 discards 3 unread
        cyc(1, 8'hA5, 0, 1, 1, 0);
        chk("R8", "fill after sof+write", 32'(cpu_fill_o), 1);
        chk("R4", "unread bytes discarded", 32'(bus_cnt_o), 0);
        chk("R5", "irq on corrupted sof", 32'(sof_irq_o), 1);
        // R6: overflow
        for (int i = 0; i < DEPTH + 2; i++) cyc(1, DW'(i), 0, 0, 0, 0);
        chk("R6", "fill capped", 32'(cpu_fill_o), DEPTH);
        chk("R6", "overflow sticky", 32'(status_o[1]), 1);
        cyc(0, 0, 0, 1, 0, 3'b011);
        // R7: drain then underrun
        for (int i = 0; i < DEPTH + 2; i++) cyc(0, 0, 1, 0, 0, 0);
        chk("R7", "underrun set", 32'(status_o[2]), 1);
        chk("R7", "empty reads zero", 32'(bus_rd_data_o), 0);
        cyc(0, 0, 0, 0, 0, 3'b100);
        // R9: read during frame start is ignored
        for (int i = 0; i < 4; i++) cyc(1, DW'(8'h40 + i), 0, 0, 0, 0);
        cyc(0, 0, 1, 1, 0, 0);
        chk("R9", "no pop at sof", 32'(bus_cnt_o), 4);
        chk("R9", "no underrun at sof", 32'(status_o[2]), 0);

        // Random mix of all strobes
        for (int i = 0; i < 3000; i++) begin
            cyc(($urandom % 3) == 0, DW'($urandom), ($urandom % 3) == 0,
                ($urandom % 23) == 0, ($urandom % 2) == 0,
                (($urandom % 5) == 0) ? 3'($urandom) : 3'b000);
        end
        compare_all();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule